// File: doc/BRIEF.md
# Event Performance Monitor Unit

This block counts activity inside a processor core. It has three 32-bit counters. A cycle counter runs at the full clock rate, or at one sixty-fourth of it. Two event counters each count one core event input, chosen by an 8-bit code. A single control register governs all three counters, and three counter registers can be read and written through a simple register port.

The event counters have no enable bits of their own. To stop one, software selects a code that never fires. Code 0x20 is the usual choice, because the trace output it names is tied inactive here.

When a counter wraps from all ones to zero, it raises a sticky overflow flag. One level interrupt is asserted while any flag is set and its interrupt enable is set. Software clears a flag by writing a one to it. This means software can write the whole control value back to acknowledge an interrupt without changing anything else.

Top module: `evt_perf_monitor`

## Requirements
- R1: After reset, the control register and all three counters read zero and `irq` is low.
- R2: While control bit 0 (run enable) is clear, no counter changes, whatever the event inputs do.
- R3: When run enable is set, each event counter increments once in every cycle in which the core event input indexed by its select code is high. Codes 0x00 to 0x12 index `core_evt[18:0]`. Event counter 0 takes its code from control bits 27:20, and event counter 1 from bits 19:12.
- R4: A select code above 0x12, including 0x20, never increments its counter.
- R5: When run enable is set and control bit 3 is clear, the cycle counter increments every clock. When bit 3 is set, it increments once every 64 enabled clocks, with the first increment on the 64th clock after bit 3 is written.
- R6: Writing a 1 to control bit 1 zeroes both event counters. Writing a 1 to control bit 2 zeroes the cycle counter. Both bits always read back as zero.
- R7: Register addresses are 0 for control, 1 for the cycle counter, 2 for event counter 0 and 3 for event counter 1. A write to a counter address loads that counter, and this load takes precedence over an increment in the same cycle.
- R8: Overflow flags sit at control bit 8 (event counter 0), bit 9 (event counter 1) and bit 10 (cycle counter). A flag is set when its counter increments from 0xFFFFFFFF to zero, and it stays set until software clears it.
- R9: Writing a 1 to a flag bit clears it, and writing a 0 leaves it unchanged. If an overflow and a clear of the same flag fall in the same cycle, the flag stays set.
- R10: `irq` is high exactly when some overflow flag is set together with its interrupt enable. The interrupt enables are control bit 4 for event counter 0, bit 5 for event counter 1 and bit 6 for the cycle counter.
- R11: A control read returns the stored run enable, divide, interrupt-enable, flag and select fields in their positions. Bits 31:28, 11, 7, 2 and 1 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_evt | input | 19 | Single-cycle event pulses from the core, indexed by select code |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Combined overflow interrupt, level |

## Verification
Two pairs of functions can collide in one clock edge, and each pair is forced to meet on purpose.

The first pair is a counter wrapping while software clears that counter's flag. The bench loads event counter 0 with 0xFFFFFFFF. It then drives the selected event in the same cycle as a control write that carries a one in flag bit 8. The flag must read set afterwards, and a second, lone clear must then remove it.

The second pair is a software load and an increment on the same edge. The bench holds the selected event high during a counter write, and the counter must show the written value with no increment added.

// File: rtl/pmu_pkg.sv
`timescale 1ns/1ps
package pmu_pkg;
    localparam int CNT_W        = 32;
    localparam int SEL_W        = 8;
    localparam int NUM_CORE_EVT = 19;
    localparam int DIV_LOG2     = 6;
    localparam int NUM_CNT      = 3;
    localparam int REG_W        = 32;

    // control register field positions
    localparam int B_RUN     = 0;
    localparam int B_CLR_EV  = 1;
    localparam int B_CLR_CY  = 2;
    localparam int B_DIV     = 3;
    localparam int B_IE_LO   = 4;
    localparam int B_OVF_LO  = 8;
    localparam int B_SEL1_LO = 12;
    localparam int B_SEL0_LO = 20;

    // flag / enable / counter slot order
    localparam int SLOT_EV0 = 0;
    localparam int SLOT_EV1 = 1;
    localparam int SLOT_CYC = 2;

    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_CYC  = 2'd1,
        RA_EV0  = 2'd2,
        RA_EV1  = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/pmu_ctrl_reg.sv
`timescale 1ns/1ps
module pmu_ctrl_reg
    import pmu_pkg::*;
#(
    parameter int SW = SEL_W,
    parameter int NC = NUM_CNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wdata,
    input  logic [NC-1:0]     ovf_set,
    output logic              run_en,
    output logic              div_sel,
    output logic [NC-1:0]     ie,
    output logic [NC-1:0]     ovf,
    output logic [SW-1:0]     sel0,
    output logic [SW-1:0]     sel1,
    output logic              clr_ev,
    output logic              clr_cy,
    output logic [REG_W-1:0]  rdata,
    output logic              irq
);
    logic [NC-1:0] w1c;
    logic [NC-1:0] ovf_next;
    logic          unused_bits;

    assign unused_bits = ^{wdata[REG_W-1:B_SEL0_LO+SW], wdata[B_OVF_LO+NC +: 1],
                           wdata[B_IE_LO+NC +: 1]};

    assign w1c      = wr_en ? wdata[B_OVF_LO +: NC] : '0;
    // a fresh overflow outranks a clear landing on the same edge
    assign ovf_next = (ovf & ~w1c) | ovf_set;
    assign clr_ev   = wr_en & wdata[B_CLR_EV];
    assign clr_cy   = wr_en & wdata[B_CLR_CY];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_en  <= 1'b0;
            div_sel <= 1'b0;
            ie      <= '0;
            sel0    <= '0;
            sel1    <= '0;
        end else if (wr_en) begin
            run_en  <= wdata[B_RUN];
            div_sel <= wdata[B_DIV];
            ie      <= wdata[B_IE_LO +: NC];
            sel0    <= wdata[B_SEL0_LO +: SW];
            sel1    <= wdata[B_SEL1_LO +: SW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovf <= '0;
        else        ovf <= ovf_next;
    end

    always_comb begin
        rdata                   = '0;
        rdata[B_RUN]            = run_en;
        rdata[B_DIV]            = div_sel;
        rdata[B_IE_LO +: NC]    = ie;
        rdata[B_OVF_LO +: NC]   = ovf;
        rdata[B_SEL1_LO +: SW]  = sel1;
        rdata[B_SEL0_LO +: SW]  = sel0;
    end

    assign irq = |(ovf & ie);
endmodule

// File: rtl/pmu_evt_sel.sv
`timescale 1ns/1ps
module pmu_evt_sel
    import pmu_pkg::*;
#(
    parameter int SW = SEL_W,
    parameter int NE = NUM_CORE_EVT
) (
    input  logic [NE-1:0] core_evt,
    input  logic [SW-1:0] code,
    output logic          hit
);
    // codes with no matching input (trace output, unassigned) never hit
    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < NE; i++) begin
            if (code == SW'(i)) hit = hit | core_evt[i];
        end
    end
endmodule

// File: rtl/pmu_prescale.sv
`timescale 1ns/1ps
module pmu_prescale #(
    parameter int DL = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic tick
);
    logic [DL-1:0] phase;

    assign tick = run & ~clr & (&phase);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   phase <= '0;
        else if (clr) phase <= '0;
        else if (run) phase <= phase + 1'b1;
    end
endmodule

// File: rtl/pmu_counter.sv
`timescale 1ns/1ps
module pmu_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic         wrap
);
    // priority: software load, then reset bit, then increment
    assign wrap = inc & ~wr & ~clr & (&value);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   value <= '0;
        else if (wr)  value <= wdata;
        else if (clr) value <= '0;
        else if (inc) value <= value + 1'b1;
    end
endmodule

// File: rtl/evt_perf_monitor.sv
`timescale 1ns/1ps
module evt_perf_monitor
    import pmu_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int NE = NUM_CORE_EVT,
    parameter int DL = DIV_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NE-1:0]    core_evt,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq
);
    localparam int NC = NUM_CNT;

    reg_addr_e              addr;
    logic                   run_en, div_sel, clr_ev, clr_cy, tick;
    logic [NC-1:0]          ie, ovf, wrap, inc, clr, wr;
    logic [SEL_W-1:0]       sel0, sel1;
    logic [1:0][SEL_W-1:0]  sel;
    logic [1:0]             hit;
    logic [NC-1:0][CW-1:0]  cnt;
    logic [REG_W-1:0]       ctrl_rd;
    logic [CW-1:0]          cnt_cyc, cnt_ev0, cnt_ev1;

    assign addr = reg_addr_e'(reg_addr);

    pmu_ctrl_reg #(.SW(SEL_W), .NC(NC)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr && addr == RA_CTRL),
        .wdata   (reg_wdata),
        .ovf_set (wrap),
        .run_en  (run_en),
        .div_sel (div_sel),
        .ie      (ie),
        .ovf     (ovf),
        .sel0    (sel0),
        .sel1    (sel1),
        .clr_ev  (clr_ev),
        .clr_cy  (clr_cy),
        .rdata   (ctrl_rd),
        .irq     (irq)
    );

    assign sel[SLOT_EV0] = sel0;
    assign sel[SLOT_EV1] = sel1;

    for (genvar g = 0; g < 2; g++) begin : g_evsel
        pmu_evt_sel #(.SW(SEL_W), .NE(NE)) u_sel (
            .core_evt (core_evt),
            .code     (sel[g]),
            .hit      (hit[g])
        );
        assign inc[g] = run_en & hit[g];
        assign clr[g] = clr_ev;
    end

    pmu_prescale #(.DL(DL)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_en & div_sel),
        .clr   (clr_cy | ~div_sel),
        .tick  (tick)
    );
    assign inc[SLOT_CYC] = run_en & (div_sel ? tick : 1'b1);
    assign clr[SLOT_CYC] = clr_cy;

    assign wr[SLOT_EV0] = reg_wr && addr == RA_EV0;
    assign wr[SLOT_EV1] = reg_wr && addr == RA_EV1;
    assign wr[SLOT_CYC] = reg_wr && addr == RA_CYC;

    for (genvar g = 0; g < NC; g++) begin : g_cnt
        pmu_counter #(.W(CW)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr[g]),
            .wr    (wr[g]),
            .wdata (reg_wdata[CW-1:0]),
            .inc   (inc[g]),
            .value (cnt[g]),
            .wrap  (wrap[g])
        );
    end

    assign cnt_cyc = cnt[SLOT_CYC];
    assign cnt_ev0 = cnt[SLOT_EV0];
    assign cnt_ev1 = cnt[SLOT_EV1];

    always_comb begin
        unique case (addr)
            RA_CTRL: reg_rdata = ctrl_rd;
            RA_CYC:  reg_rdata = REG_W'(cnt_cyc);
            RA_EV0:  reg_rdata = REG_W'(cnt_ev0);
            RA_EV1:  reg_rdata = REG_W'(cnt_ev1);
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pmu_sva.sv
`timescale 1ns/1ps
module pmu_sva
    import pmu_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int NE = NUM_CORE_EVT
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [REG_W-1:0] reg_wdata,
    input logic             run_en,
    input logic             div_sel,
    input logic [SEL_W-1:0] sel0,
    input logic [2:0]       ovf,
    input logic [CW-1:0]    cnt_cyc,
    input logic [CW-1:0]    cnt_ev0,
    input logic [CW-1:0]    cnt_ev1
);
    AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !reg_wr) |=> ($stable(cnt_cyc) && $stable(cnt_ev0) && $stable(cnt_ev1))); // R2

    AST_DEAD_CODE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && sel0 >= SEL_W'(NE) && !reg_wr) |=> $stable(cnt_ev0)); // R4

    AST_CYCLE_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !div_sel && !reg_wr) |=> (cnt_cyc == CW'($past(cnt_cyc) + 1'b1))); // R5

    AST_PAIR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0 && reg_wdata[B_CLR_EV]) |=> (cnt_ev0 == '0 && cnt_ev1 == '0)); // R6

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1) |=> (cnt_cyc == $past(reg_wdata[CW-1:0]))); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == 2'd0) |=> ((ovf & $past(ovf)) == $past(ovf))); // R8
endmodule

bind evt_perf_monitor pmu_sva #(.CW(CW), .NE(NE)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .run_en    (run_en),
    .div_sel   (div_sel),
    .sel0      (sel0),
    .ovf       (ovf),
    .cnt_cyc   (cnt_cyc),
    .cnt_ev0   (cnt_ev0),
    .cnt_ev1   (cnt_ev1)
);

// File: tb/tb_evt_perf_monitor.sv
`timescale 1ns/1ps
module tb_evt_perf_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [18:0] core_evt = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    evt_perf_monitor dut (
        .clk(clk), .rst_n(rst_n), .core_evt(core_evt), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    localparam logic [1:0] A_CTRL = 2'd0, A_CYC = 2'd1, A_EV0 = 2'd2, A_EV1 = 2'd3;

    function automatic logic [31:0] mk(bit en, bit dv, logic [2:0] ie, logic [7:0] s0, logic [7:0] s1);
        return {4'h0, s0, s1, 1'b0, 3'b000, 1'b0, ie, dv, 2'b00, en};
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic drive_evt(logic [18:0] v, int n);
        core_evt = v; idle(n); core_evt = '0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk(v == 0, "R1 reg zero after reset", v, 0);
        end
        chk(irq == 1'b0, "R1 irq low after reset", 32'(irq), 0);
    endtask

    task automatic t_run_enable;
        logic [31:0] v;
        wr(A_CTRL, mk(0, 0, 3'b000, 8'h00, 8'h01));
        drive_evt(19'h3, 5);
        rd(A_EV0, v); chk(v == 0, "R2 ev0 frozen while off", v, 0);
        rd(A_CYC, v); chk(v == 0, "R2 cycle frozen while off", v, 0);
        wr(A_CTRL, mk(1, 0, 3'b000, 8'h00, 8'h01));
        drive_evt(19'h3, 3);
        wr(A_CTRL, mk(0, 0, 3'b000, 8'h00, 8'h01));
        rd(A_EV1, v); chk(v == 3, "R2 ev1 counts once enabled", v, 3);
        drive_evt(19'h3, 4);
        rd(A_EV0, v); chk(v == 3, "R2 ev0 stops after disable", v, 3);
    endtask

    task automatic t_select;
        logic [31:0] v;
        wr(A_EV0, 0); wr(A_EV1, 0);
        wr(A_CTRL, mk(1, 0, 3'b000, 8'h12, 8'h07));
        drive_evt(19'h40000, 4);
        drive_evt(19'h00080, 2);
        drive_evt(19'h00008, 5);
        wr(A_CTRL, mk(0, 0, 3'b000, 8'h12, 8'h07));
        rd(A_EV0, v); chk(v == 4, "R3 ev0 counts input 18", v, 4);
        rd(A_EV1, v); chk(v == 2, "R3 ev1 counts input 7", v, 2);
    endtask

    task automatic t_dead_code;
        logic [31:0] v;
        wr(A_EV0, 0); wr(A_EV1, 0);
        wr(A_CTRL, mk(1, 0, 3'b000, 8'h20, 8'h13));
        drive_evt('1, 10);
        wr(A_CTRL, mk(0, 0, 3'b000, 8'h20, 8'h13));
        rd(A_EV0, v); chk(v == 0, "R4 code 0x20 frozen", v, 0);
        rd(A_EV1, v); chk(v == 0, "R4 code 0x13 frozen", v, 0);
    endtask

    task automatic t_cycle_rate;
        logic [31:0] v;
        wr(A_CYC, 0);
        wr(A_CTRL, mk(1, 0, 3'b000, 8'h20, 8'h20));
        idle(10);
        rd(A_CYC, v); chk(v == 10, "R5 full-rate cycle count", v, 10);
        wr(A_CTRL, mk(0, 0, 3'b000, 8'h20, 8'h20));
        wr(A_CYC, 0);
        wr(A_CTRL, mk(1, 1, 3'b000, 8'h20, 8'h20));
        idle(63);
        rd(A_CYC, v); chk(v == 0, "R5 divided count before 64th clock", v, 0);
        idle(1);
        rd(A_CYC, v); chk(v == 1, "R5 divided count at 64th clock", v, 1);
        wr(A_CTRL, mk(0, 0, 3'b000, 8'h20, 8'h20));
    endtask

    task automatic t_reset_bits;
        logic [31:0] v;
        wr(A_EV0, 5); wr(A_EV1, 6); wr(A_CYC, 7);
        wr(A_CTRL, mk(0, 0, 3'b000, 8'h20, 8'h20) | 32'h2);
        rd(A_EV0, v); chk(v == 0, "R6 pair reset ev0", v, 0);
        rd(A_EV1, v); chk(v == 0, "R6 pair reset ev1", v, 0);
        rd(A_CYC, v); chk(v == 7, "R6 pair reset spares cycle", v, 7);
        wr(A_CTRL, mk(0, 0, 3'b000, 8'h20, 8'h20) | 32'h4);
        rd(A_CYC, v); chk(v == 0, "R6 cycle reset", v, 0);
        rd(A_CTRL, v); chk(v[2:1] == 2'b00, "R6 reset bits read zero", 32'(v[2:1]), 0);
    endtask

    task automatic t_load_wins;
        logic [31:0] v;
        wr(A_CTRL, mk(1, 0, 3'b000, 8'h05, 8'h20));
        core_evt = 19'h20;
        wr(A_EV0, 100);
        core_evt = '0;
        rd(A_EV0, v); chk(v == 100, "R7 load beats increment", v, 100);
        wr(A_CTRL, mk(0, 0, 3'b000, 8'h05, 8'h20));
    endtask

    task automatic t_overflow_irq;
        logic [31:0] v;
        wr(A_EV1, 32'hFFFF_FFFF);
        wr(A_CTRL, mk(1, 0, 3'b000, 8'h20, 8'h09));
        drive_evt(19'h200, 1);
        rd(A_EV1, v); chk(v == 0, "R8 ev1 wrapped to zero", v, 0);
        rd(A_CTRL, v); chk(v[9] == 1'b1, "R8 ev1 flag set", 32'(v[9]), 1);
        chk(irq == 1'b0, "R10 irq low with enable clear", 32'(irq), 0);
        wr(A_CTRL, mk(0, 0, 3'b010, 8'h20, 8'h09));
        idle(3);
        rd(A_CTRL, v); chk(v[9] == 1'b1, "R9 zero write keeps flag", 32'(v[9]), 1);
        chk(irq == 1'b1, "R10 irq high with flag and enable", 32'(irq), 1);
        wr(A_CTRL, mk(0, 0, 3'b010, 8'h20, 8'h09) | 32'h200);
        rd(A_CTRL, v); chk(v[10:8] == 3'b000, "R9 one write clears flag", 32'(v[10:8]), 0);
        chk(irq == 1'b0, "R10 irq drops after clear", 32'(irq), 0);
    endtask

    task automatic t_race;
        logic [31:0] v;
        wr(A_CTRL, mk(1, 0, 3'b001, 8'h05, 8'h20));
        wr(A_EV0, 32'hFFFF_FFFF);
        core_evt = 19'h20;
        wr(A_CTRL, mk(1, 0, 3'b001, 8'h05, 8'h20) | 32'h100);
        core_evt = '0;
        rd(A_EV0, v); chk(v == 0, "R8 ev0 wrapped in race", v, 0);
        rd(A_CTRL, v); chk(v[8] == 1'b1, "R9 overflow beats same-cycle clear", 32'(v[8]), 1);
        chk(irq == 1'b1, "R10 irq from ev0 flag", 32'(irq), 1);
        wr(A_CTRL, mk(0, 0, 3'b001, 8'h05, 8'h20) | 32'h100);
        rd(A_CTRL, v); chk(v[8] == 1'b0, "R9 later clear removes flag", 32'(v[8]), 0);
    endtask

    task automatic t_readback;
        logic [31:0] v;
        wr(A_CTRL, mk(0, 1, 3'b111, 8'hAB, 8'hCD));
        rd(A_CTRL, v);
        chk(v == mk(0, 1, 3'b111, 8'hAB, 8'hCD), "R11 control readback", v, mk(0, 1, 3'b111, 8'hAB, 8'hCD));
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, v);
        wr(A_CTRL, 0);
        chk(v == 32'h0FFF_F079, "R11 reserved bits read zero", v, 32'h0FFF_F079);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset;
        t_run_enable;
        t_select;
        t_dead_code;
        t_cycle_rate;
        t_reset_bits;
        t_load_wins;
        t_overflow_irq;
        t_race;
        t_readback;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule